// File: doc/BRIEF.md
# Bit-Interleave Lane Multiplexer and Rotating Demultiplexer

This block joins four parallel lanes into one serial bit stream and splits such a stream back into four lanes. The transmit half takes one four-bit word every four clocks, one bit per lane, and shifts the bits out one per clock, lane 0 first and lane 3 last. Lane 3 is the marker lane. It is inverted before it goes onto the link, so that a frame detector downstream has a known-polarity reference.

The receive half collects four consecutive serial bits into a word and inverts the marker lane back. It then presents the word on four output lanes through a rotation stage. When the receiver's bit phase does not line up with the transmitter's, every lane lands one or more positions away from its true place. An external frame detector watches output lane 3 and pulses `roll`, and each pulse advances the rotation by one position until the lanes come out in their original order.

The whole block runs on a single bit-rate clock. Internal phase counters mark the word boundaries and are shown to the outside as `tx_take` and `rx_valid`.

Top module: `bitlane_muxdemux`

## Requirements
- R1: `tx_take` is high in one cycle out of every four, starting with the third cycle after reset. The word on `tx_lanes` is captured at the clock edge that ends that cycle. On the four following cycles `tx_serial` carries lane 0, then lane 1, then lane 2, then lane 3 of that word.
- R2: The marker lane (lane index 3) appears inverted on `tx_serial`. Lanes 0 to 2 pass unchanged.
- R3: The receiver places the oldest of four consecutive `rx_serial` bits in word position 0. `rx_valid` pulses for one cycle in every four, on the cycle after each `tx_take`. With zero line delay and rotation 0, `rx_lanes` equals the word captured one word period earlier.
- R4: Output lane 3 is inverted back, so a correctly aligned link returns the original marker-lane data.
- R5: Output lane j carries received word position (j + rot) mod 4. The 2-bit rotation index rot advances by one after each clock edge at which `roll` is high, and it wraps from 3 to 0.
- R6: While `rst` is high, the rotation index and both phase counters are held at 0, and `tx_serial`, `tx_take`, `rx_valid` and `rx_lanes` are all 0.
- R7: In a loopback where the line delay is d cycles (d from 0 to 3), exactly d roll pulses after reset bring the transmitted lanes back out in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_lanes | input | 4 | Parallel word to transmit, one bit per lane |
| tx_take | output | 1 | High in the cycle whose closing edge captures `tx_lanes` |
| tx_serial | output | 1 | Interleaved serial output, one bit per clock |
| rx_serial | input | 1 | Serial input, one bit per clock |
| roll | input | 1 | One-cycle request to advance the lane rotation |
| rx_lanes | output | 4 | Deinterleaved, rotated and marker-restored lanes |
| rx_valid | output | 1 | One-cycle strobe when `rx_lanes` updates |

## Verification
The assertions assume that `roll` arrives as an isolated one-cycle pulse. They also assume that `tx_lanes` is steady through each `tx_take` cycle, because the first serial bit is compared with the lane 0 value sampled there. The stimulus changes `tx_lanes` only on the falling edge that opens a take cycle. It raises `roll` only on the falling edge right after an `rx_valid` cycle, so each rotation step lands well before the next word is captured. The loopback delay is changed only while the block and the bench's delay line are held in reset, so no check ever sees a word that straddles two delay settings.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    localparam int MXD_LANES = 4;
    localparam int MXD_IDX_W = $clog2(MXD_LANES);

    typedef logic [MXD_LANES-1:0] lane_word_t;
    typedef logic [MXD_IDX_W-1:0] lane_idx_t;

    // A received word together with its word-boundary strobe.
    typedef struct packed {
        logic       strobe;
        lane_word_t bits;
    } lane_beat_t;

    localparam lane_idx_t LAST_IDX = lane_idx_t'(MXD_LANES - 1);

    // One-hot mask that selects the marker lane.
    function automatic lane_word_t marker_mask(input int unsigned marker);
        lane_word_t m;
        for (int k = 0; k < MXD_LANES; k++) begin
            m[k] = (k == int'(marker));
        end
        return m;
    endfunction

    // Index increment that wraps at the lane count.
    function automatic lane_idx_t idx_step(input lane_idx_t i);
        return (i == LAST_IDX) ? lane_idx_t'(0) : i + lane_idx_t'(1);
    endfunction

endpackage

// File: rtl/mxd_phase_ctr.sv
module mxd_phase_ctr
    import mxd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output lane_idx_t phase,
    output logic      last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= idx_step(phase);
        end
    end

    assign last = (phase == LAST_IDX);

endmodule

// File: rtl/mxd_tx_serializer.sv
module mxd_tx_serializer
    import mxd_pkg::*;
#(
    parameter int MARKER_LANE = MXD_LANES - 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  lane_word_t lanes,
    output logic       ser
);

    localparam lane_word_t FLIP = marker_mask(MARKER_LANE);

    lane_word_t shreg;

    // Loading puts lane 0 in bit 0, so lane 0 leaves first.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= lanes ^ FLIP;
        end else begin
            shreg <= {1'b0, shreg[MXD_LANES-1:1]};
        end
    end

    assign ser = shreg[0];

endmodule

// File: rtl/mxd_rx_deserializer.sv
module mxd_rx_deserializer
    import mxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ser,
    input  logic       last,
    output lane_beat_t beat
);

    lane_word_t shreg;

    // New bits enter at the top, so the oldest bit ends up in position 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {ser, shreg[MXD_LANES-1:1]};
        end
    end

    always_comb begin
        beat.bits   = {ser, shreg[MXD_LANES-1:1]};
        beat.strobe = last;
    end

endmodule

// File: rtl/mxd_lane_rotator.sv
module mxd_lane_rotator
    import mxd_pkg::*;
#(
    parameter int MARKER_LANE = MXD_LANES - 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       roll,
    input  lane_beat_t beat,
    output lane_word_t lanes_out,
    output logic       valid_out,
    output lane_idx_t  rot
);

    localparam lane_word_t FLIP = marker_mask(MARKER_LANE);

    lane_word_t mapped;

    always_ff @(posedge clk) begin
        if (rst) begin
            rot <= '0;
        end else if (roll) begin
            rot <= idx_step(rot);
        end
    end

    // Output lane j takes word position (j + rot) mod lanes.
    for (genvar j = 0; j < MXD_LANES; j++) begin : g_map
        lane_idx_t sel;
        assign sel       = rot + lane_idx_t'(j);
        assign mapped[j] = beat.bits[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_out <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= beat.strobe;
            if (beat.strobe) begin
                lanes_out <= mapped ^ FLIP;
            end
        end
    end

endmodule

// File: rtl/bitlane_muxdemux.sv
module bitlane_muxdemux
    import mxd_pkg::*;
#(
    parameter int MARKER_LANE = MXD_LANES - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MXD_LANES-1:0] tx_lanes,
    output logic                 tx_take,
    output logic                 tx_serial,
    input  logic                 rx_serial,
    input  logic                 roll,
    output logic [MXD_LANES-1:0] rx_lanes,
    output logic                 rx_valid
);

    lane_idx_t  tx_phase;
    lane_idx_t  rx_phase;
    logic       rx_last;
    lane_beat_t rx_beat;
    lane_idx_t  rot_idx;

    mxd_phase_ctr u_tx_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (tx_phase),
        .last  (tx_take)
    );

    mxd_tx_serializer #(.MARKER_LANE(MARKER_LANE)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (tx_take),
        .lanes (tx_lanes),
        .ser   (tx_serial)
    );

    mxd_phase_ctr u_rx_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (rx_phase),
        .last  (rx_last)
    );

    mxd_rx_deserializer u_rx (
        .clk  (clk),
        .rst  (rst),
        .ser  (rx_serial),
        .last (rx_last),
        .beat (rx_beat)
    );

    mxd_lane_rotator #(.MARKER_LANE(MARKER_LANE)) u_rot (
        .clk       (clk),
        .rst       (rst),
        .roll      (roll),
        .beat      (rx_beat),
        .lanes_out (rx_lanes),
        .valid_out (rx_valid),
        .rot       (rot_idx)
    );

endmodule

// File: rtl/mxd_checker.sv
module mxd_checker
    import mxd_pkg::*;
#(
    parameter int MARKER_LANE = MXD_LANES - 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 roll,
    input logic                 tx_take,
    input logic                 tx_serial,
    input logic                 rx_valid,
    input logic [MXD_LANES-1:0] tx_lanes,
    input logic [MXD_IDX_W-1:0] rot_idx
);

    localparam logic FLIP0 = (MARKER_LANE == 0);

    AST_ROLL_STEP: assert property (@(posedge clk) disable iff (rst)
        roll |=> (rot_idx == lane_idx_t'($past(rot_idx) + lane_idx_t'(1)))); // R5

    AST_ROT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(rot_idx)); // R5

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> (tx_serial == ($past(tx_lanes[0]) ^ FLIP0))); // R1

    AST_TAKE_GAP: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> !tx_take); // R1

    AST_RX_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> rx_valid); // R3

    AST_RX_GAP: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (rot_idx == '0 && !rx_valid && !tx_take)); // R6

endmodule

bind bitlane_muxdemux mxd_checker #(.MARKER_LANE(MARKER_LANE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .roll      (roll),
    .tx_take   (tx_take),
    .tx_serial (tx_serial),
    .rx_valid  (rx_valid),
    .tx_lanes  (tx_lanes),
    .rot_idx   (rot_idx)
);

// File: tb/bitlane_muxdemux_bench.sv
module bitlane_muxdemux_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tx_lanes = 4'h0;
    logic       tx_take;
    logic       tx_serial;
    logic       rx_serial;
    logic       roll = 1'b0;
    logic [3:0] rx_lanes;
    logic       rx_valid;

    logic [3:0] dly;
    int         line_d = 0;
    int         cyc = 0;
    int         rx_m = 0;
    int         tx_m = 0;
    int         exp_rot = 0;
    int         checks = 0;
    int         fails = 0;
    bit         got_valid = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    bitlane_muxdemux u_bitlane_muxdemux (
        .clk       (clk),
        .rst       (rst),
        .tx_lanes  (tx_lanes),
        .tx_take   (tx_take),
        .tx_serial (tx_serial),
        .rx_serial (rx_serial),
        .roll      (roll),
        .rx_lanes  (rx_lanes),
        .rx_valid  (rx_valid)
    );

    // Loopback line with a selectable delay of 0 to 3 cycles.
    always_ff @(posedge clk) begin
        if (rst) dly <= 4'h0;
        else     dly <= {dly[2:0], tx_serial};
    end

    always_comb begin
        case (line_d)
            1:       rx_serial = dly[0];
            2:       rx_serial = dly[1];
            3:       rx_serial = dly[2];
            default: rx_serial = tx_serial;
        endcase
    end

    // Word m sent over the link; word 0 stands for the idle pre-load state.
    function automatic logic [3:0] fword(input int m);
        if (m <= 0) return 4'h0;
        return 4'((m * 5 + m / 4 + 3) % 16);
    endfunction

    // Expected receive word m for line delay d and rotation r.
    function automatic logic [3:0] exp_rx(input int m, input int d, input int r);
        logic [3:0] e;
        for (int j = 0; j < 4; j++) begin
            int         pos;
            int         src;
            int         w;
            logic [3:0] wd;
            pos = (j + r) % 4;
            src = pos - d;
            w   = m - 1;
            if (src < 0) begin
                src = src + 4;
                w   = m - 2;
            end
            wd   = fword(w);
            e[j] = wd[src] ^ (src == 3) ^ (j == 3);
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d, delay %0d)", tag, act, exp, cyc, line_d);
        end
    endtask

    // Transmit driver: a new word on every take cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                tx_m     = 0;
                tx_lanes = 4'h0;
            end else if (tx_take) begin
                tx_m     = tx_m + 1;
                tx_lanes = fword(tx_m);
            end
        end
    end

    task automatic tick();
        logic [3:0] ex;
        int         ph;
        @(negedge clk);
        got_valid = 0;
        if (roll) begin
            roll    = 1'b0;
            exp_rot = (exp_rot + 1) % 4;
        end
        cyc++;
        chk(tx_take === (cyc % 4 == 3), "R1 tx_take cadence", {3'b0, tx_take}, {3'b0, cyc % 4 == 3});
        chk(rx_valid === (cyc % 4 == 0), "R3 rx_valid cadence", {3'b0, rx_valid}, {3'b0, cyc % 4 == 0});
        if (line_d == 0 && cyc >= 4 && cyc < 48) begin
            ph = cyc % 4;
            ex = fword(cyc / 4);
            if (ph == 3)
                chk(tx_serial === ~ex[3], "R2 marker bit inverted", {3'b0, tx_serial}, {3'b0, ~ex[3]});
            else
                chk(tx_serial === ex[ph], "R1 serial lane order", {3'b0, tx_serial}, {3'b0, ex[ph]});
        end
        if (rx_valid) begin
            got_valid = 1;
            rx_m++;
            if (rx_m >= 3) begin
                ex = exp_rx(rx_m, line_d, exp_rot);
                if (exp_rot == line_d)
                    chk(rx_lanes === ex, "R7 R4 lane order recovered", rx_lanes, ex);
                else if (line_d == 0 && exp_rot == 0)
                    chk(rx_lanes === ex, "R3 aligned receive", rx_lanes, ex);
                else
                    chk(rx_lanes === ex, "R5 rotated mapping", rx_lanes, ex);
            end
        end
    endtask

    task automatic wait_word();
        do tick(); while (!got_valid);
    endtask

    task automatic do_reset(input int d);
        @(negedge clk);
        rst    = 1'b1;
        roll   = 1'b0;
        line_d = d;
        repeat (3) begin
            @(negedge clk);
            chk(tx_serial === 1'b0, "R6 tx_serial in reset", {3'b0, tx_serial}, 4'h0);
            chk(tx_take === 1'b0, "R6 tx_take in reset", {3'b0, tx_take}, 4'h0);
            chk(rx_valid === 1'b0, "R6 rx_valid in reset", {3'b0, rx_valid}, 4'h0);
            chk(rx_lanes === 4'h0, "R6 rx_lanes in reset", rx_lanes, 4'h0);
        end
        rst     = 1'b0;
        cyc     = 0;
        rx_m    = 0;
        exp_rot = 0;
    endtask

    initial begin
        for (int d = 0; d < 4; d++) begin
            do_reset(d);
            // Sweep every rotation, then one more roll to see the wrap to 0.
            for (int r = 0; r < 5; r++) begin
                repeat (3) wait_word();
                if (r < 4) roll = 1'b1;
            end
            tick();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule